// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block produces the word address for a synchronous burst memory. A burst begins when either of two active-low start strobes is sampled low on a rising clock edge. The external address is then captured. Its upper bits are held for the rest of the burst, and its two low bits become the starting beat of a 2-bit burst counter. On each later edge where the active-low advance input is low, the counter steps to the next beat within a group of four.

A pin selects how beats map onto the low address bits. In linear order the start value is incremented modulo four. In interleaved order the start value is XORed with a running beat count. Bursting is optional: the strobe may be asserted on every cycle, and the output then follows the external address with a single register of latency. A burst-valid flag rises on the first strobe after reset. The block has no data stream, so there is no valid/ready handshake. All pins are plain control and status signals.

Top module: `bseq_top`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next output has `addr_out` equal to 0 and `burst_valid` equal to 0.
- R2: When `strb_proc_n` is sampled low, the next cycle shows `addr_out` equal to the sampled `ext_addr` and `burst_valid` equal to 1.
- R3: When `strb_ctl_n` is sampled low and `strb_proc_n` is high, the next cycle shows `addr_out` equal to the sampled `ext_addr` and `burst_valid` equal to 1.
- R4: When both strobes are low in the same cycle, the processor strobe wins, and the load is identical to a processor-strobe load.
- R5: With `order_sel_n` = 0 (linear), each edge with `adv_n` low, no strobe and `burst_valid` = 1 sets `addr_out[1:0]` to the previous value plus 1 modulo 4.
- R6: With `order_sel_n` = 1 (interleaved), the k-th advance after a load gives `addr_out[1:0]` = start XOR k, for k = 0..3, where start is the loaded `ext_addr[1:0]`.
- R7: On an edge with `adv_n` high and no strobe, `addr_out` keeps its value.
- R8: `addr_out[ADDR_W-1:2]` stays at the loaded value through every advance, including the wrap from beat 3 to beat 0. The counter never carries into the upper bits.
- R9: A strobe on every cycle loads a new address on every cycle. Each output equals the address sampled one edge earlier.
- R10: While `burst_valid` is 0, a low `adv_n` has no effect, and `addr_out` stays 0.
- R11: A strobe sampled low together with a low `adv_n` loads the external address, and no advance takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W | External word address |
| strb_proc_n | input | 1 | Processor start strobe, active low, higher priority |
| strb_ctl_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance enable, active low |
| order_sel_n | input | 1 | Beat order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current word address |
| burst_valid | output | 1 | High once an address has been loaded since reset |

## Verification
The bound checker watches every cycle for the following: strobe loads land one edge later, held addresses stay stable, linear steps add one, the upper bits never move without a load, and reset clears the outputs. The interleaved beat sequence for each start value depends on a count since the load. Only the bench scenarios show that sequence, along with the wrap from beat 3 back to the start group, the equivalence of a both-strobes load and the ignored advance before the first load.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // map a beat count onto the low address bits
  function automatic beat_t map_beat(input logic interleave, input beat_t start, input beat_t k);
    beat_t r;
    if (interleave) r = start ^ k;
    else            r = start + k;
    return r;
  endfunction
endpackage

// File: rtl/bseq_strobe_arb.sv
module bseq_strobe_arb (
  input  logic strb_proc_n,
  input  logic strb_ctl_n,
  output logic load,
  output logic [1:0] grant
);
  // processor strobe has priority; either strobe loads identically
  always_comb begin
    grant = 2'b00;
    if (!strb_proc_n)     grant = 2'b01;
    else if (!strb_ctl_n) grant = 2'b10;
    load = |grant;
  end
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import bseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  step,
  input  beat_t start_in,
  output beat_t start_q,
  output beat_t beat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      start_q <= start_in;
      beat_q  <= '0;
    end else if (step) begin
      beat_q  <= beat_q + beat_t'(1);
    end
  end
endmodule

// File: rtl/bseq_addr_hold.sv
module bseq_addr_hold #(
  parameter int HI_W = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [HI_W-1:0] hi_in,
  output logic [HI_W-1:0] hi_q,
  output logic            valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      hi_q    <= hi_in;
      valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bseq_top.sv
module bseq_top
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strb_proc_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              order_sel_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_valid
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic        load;
  logic [1:0]  grant;
  logic        step;
  beat_t       start_q, beat_q, lo;
  logic [HI_W-1:0] hi_q;

  bseq_strobe_arb u_arb (
    .strb_proc_n(strb_proc_n),
    .strb_ctl_n (strb_ctl_n),
    .load       (load),
    .grant      (grant)
  );

  assign step = !adv_n && burst_valid && (grant == 2'b00);

  bseq_beat_ctr u_ctr (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .start_in(ext_addr[BEAT_W-1:0]),
    .start_q (start_q),
    .beat_q  (beat_q)
  );

  bseq_addr_hold #(.HI_W(HI_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .hi_in  (ext_addr[ADDR_W-1:BEAT_W]),
    .hi_q   (hi_q),
    .valid_q(burst_valid)
  );

  assign lo       = map_beat(order_sel_n, start_q, beat_q);
  assign addr_out = {hi_q, lo};
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              strb_proc_n,
  input logic              strb_ctl_n,
  input logic              adv_n,
  input logic              order_sel_n,
  input logic [ADDR_W-1:0] addr_out,
  input logic              burst_valid
);
  logic ld;
  assign ld = !strb_proc_n || !strb_ctl_n;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (addr_out == '0 && !burst_valid)); // R1
  AST_LOAD_PROC: assert property (@(posedge clk) disable iff (rst) !strb_proc_n |=> (addr_out == $past(ext_addr) && burst_valid)); // R2
  AST_LOAD_CTL: assert property (@(posedge clk) disable iff (rst) (strb_proc_n && !strb_ctl_n) |=> (addr_out == $past(ext_addr))); // R3
  AST_LIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (burst_valid && !ld && !adv_n && !order_sel_n) |=> (order_sel_n || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1)); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ld && adv_n) |=> (order_sel_n != $past(order_sel_n) || addr_out == $past(addr_out))); // R7
  AST_HI_KEEP: assert property (@(posedge clk) disable iff (rst) !ld |=> $stable(addr_out[ADDR_W-1:2])); // R8
  AST_IDLE_ADV: assert property (@(posedge clk) disable iff (rst) (!burst_valid && !ld) |=> (addr_out == '0 && !burst_valid)); // R10
endmodule

bind bseq_top bseq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ext_addr(ext_addr), .strb_proc_n(strb_proc_n),
  .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .order_sel_n(order_sel_n),
  .addr_out(addr_out), .burst_valid(burst_valid)
);

// File: tb/bseq_top_test.sv
module bseq_top_test;
  localparam int AW = 20;
  logic clk = 0, rst = 1;
  logic [AW-1:0] ext_addr = '0;
  logic strb_proc_n = 1, strb_ctl_n = 1, adv_n = 1, order_sel_n = 0;
  logic [AW-1:0] addr_out;
  logic burst_valid;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bseq_top #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .strb_proc_n(strb_proc_n),
    .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .order_sel_n(order_sel_n),
    .addr_out(addr_out), .burst_valid(burst_valid)
  );

  task automatic check(input string req, input logic [AW:0] got, input logic [AW:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive inputs, take one edge, sample 1ns later
  task automatic cyc(input logic sp, input logic sc, input logic av, input logic [AW-1:0] a);
    strb_proc_n = sp; strb_ctl_n = sc; adv_n = av; ext_addr = a;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1;
    cyc(1, 1, 1, '0);
    cyc(1, 1, 1, '0);
    check("R1 addr", {1'b0, addr_out}, '0);
    check("R1 valid", {{AW{1'b0}}, burst_valid}, '0);
    rst = 0;
  endtask

  task automatic t_idle_adv();
    cyc(1, 1, 0, 20'h12345);
    cyc(1, 1, 0, 20'h12345);
    check("R10 idle advance", {burst_valid, addr_out}, '0);
  endtask

  task automatic t_linear(input logic [AW-1:0] a);
    logic [1:0] s;
    s = a[1:0];
    order_sel_n = 0;
    cyc(0, 1, 1, a);
    check("R2 proc load", {burst_valid, addr_out}, {1'b1, a});
    for (int k = 1; k <= 5; k++) begin
      cyc(1, 1, 0, ~a);
      check("R5 linear beat", {1'b0, addr_out[1:0]}, {{(AW-1){1'b0}}, 2'(s + 2'(k))});
      check("R8 upper held", {1'b0, addr_out[AW-1:2], 2'b00}, {1'b0, a[AW-1:2], 2'b00});
    end
  endtask

  task automatic t_interleave(input logic [AW-1:0] a);
    logic [1:0] s;
    s = a[1:0];
    order_sel_n = 1;
    cyc(1, 0, 1, a);
    check("R3 ctl load", {burst_valid, addr_out}, {1'b1, a});
    for (int k = 1; k <= 3; k++) begin
      cyc(1, 1, 0, '0);
      check("R6 interleave beat", {1'b0, addr_out}, {1'b0, a[AW-1:2], 2'(s ^ 2'(k))});
    end
  endtask

  task automatic t_hold();
    logic [AW-1:0] snap;
    order_sel_n = 0;
    cyc(0, 1, 1, 20'hABCD1);
    cyc(1, 1, 0, '0);
    snap = addr_out;
    cyc(1, 1, 1, 20'h55555);
    cyc(1, 1, 1, 20'h00000);
    check("R7 hold", {1'b0, addr_out}, {1'b0, snap});
  endtask

  task automatic t_both();
    cyc(0, 0, 1, 20'h3C3C6);
    check("R4 both strobes", {burst_valid, addr_out}, {1'b1, 20'h3C3C6});
    cyc(1, 1, 0, '0);
    check("R4 burst after both", {1'b0, addr_out}, {1'b0, 20'h3C3C7});
  endtask

  task automatic t_every_cycle();
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a;
      a = AW'(32'h1F00F * (i + 3) + i);
      cyc((i % 2) == 0 ? 1'b0 : 1'b1, 1'b0, 1'b1, a);
      check("R9 load per cycle", {1'b0, addr_out}, {1'b0, a});
    end
  endtask

  task automatic t_strobe_over_adv();
    order_sel_n = 0;
    cyc(0, 1, 1, 20'h00011);
    cyc(1, 0, 0, 20'h7777E);
    check("R11 strobe beats advance", {1'b0, addr_out}, {1'b0, 20'h7777E});
  endtask

  initial begin
    #1;
    t_reset();
    t_idle_adv();
    t_linear(20'hF00F2);
    t_linear(20'h0FFFF);
    t_interleave(20'h12342);
    t_interleave(20'h56781);
    t_hold();
    t_both();
    t_every_cycle();
    t_strobe_over_adv();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule